// File: doc/BRIEF.md
# Row/Column Coincidence Pixel Accumulator

This block builds an energy-weighted image of a 16 by 16 pixel sensor whose pixels are read out through 16 row-sum channels and 16 column-sum channels. Two event streams arrive, one from the row channels and one from the column channels. Each event carries a channel index and an amplitude. A pixel is only known once a row event and a column event fall inside the same short coincidence window. The pixel is then the intersection of that row and that column.

For every accepted pair the block reports both indices and both amplitudes. It adds the mean of the two amplitudes to the pixel's word in an on-chip image memory. A pixel's value therefore grows with its event rate times the average deposited energy, rather than counting events.

Windows that hold events on only one side are discarded and counted. Windows with more than one candidate on either side are rejected as ambiguous and counted separately. A host reads the image through a one-cycle read port and wipes it with a clear command. The clear sweeps every entry to zero while accumulation is suspended.

Top module: `rc_pixel_accum`

## Requirements
- R1: An accepted pair updates the memory word at address row*GRID + column. The host reads that same address to see the pixel.
- R2: A coincidence window opens with the first row or column event seen while no window is open, and lasts WIN consecutive cycles, the opening cycle included. If the window held exactly one row event and one column event, in any cycles of that window, evt_valid pulses high for one cycle on the cycle after the window's last cycle. During that cycle evt_row, evt_col, evt_row_amp and evt_col_amp carry the pair.
- R3: The value added to the pixel is floor((row amplitude + column amplitude) / 2).
- R4: Pixel addition saturates at 2^ACC_W - 1 and never wraps.
- R5: A window that holds events on one side only produces no event and no pixel change. It adds one to orphan_cnt, and orphan_cnt stops at its maximum.
- R6: A window that holds two or more row events, or two or more column events, produces no event and no pixel change. It adds one to ambig_cnt, and ambig_cnt stops at its maximum.
- R7: Accepted pairs arriving as fast as windows allow, including repeated hits to one pixel, each contribute their full amount; no update is lost.
- R8: A pulse on clr_start while idle raises clr_busy for exactly GRID*GRID cycles and leaves every pixel at zero. While clr_start or clr_busy is high, input events are ignored: they open no window, change no counter and raise no evt_valid. Any window already open is dropped. A clr_start pulse during a clear does not lengthen it.
- R9: rd_en with rd_addr gives rd_valid high and rd_data equal to that pixel on the next cycle. Reading does not change the image.
- R10: After reset, evt_valid, clr_busy, rd_valid, orphan_cnt and ambig_cnt are all zero. Image contents are undefined until the first clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | Row event present this cycle |
| row_idx | input | IDX_W | Row channel index |
| row_amp | input | AMP_W | Row amplitude |
| col_valid | input | 1 | Column event present this cycle |
| col_idx | input | IDX_W | Column channel index |
| col_amp | input | AMP_W | Column amplitude |
| clr_start | input | 1 | Start zeroing the image |
| rd_en | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Host read address (row*GRID + column) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | ACC_W | Pixel value read |
| clr_busy | output | 1 | Clear sweep in progress |
| evt_valid | output | 1 | Accepted pair reported this cycle |
| evt_row | output | IDX_W | Row of accepted pair |
| evt_col | output | IDX_W | Column of accepted pair |
| evt_row_amp | output | AMP_W | Row amplitude of accepted pair |
| evt_col_amp | output | AMP_W | Column amplitude of accepted pair |
| orphan_cnt | output | CNT_W | Windows discarded for a missing partner |
| ambig_cnt | output | CNT_W | Windows rejected as ambiguous |

## Verification
The bench sweeps every one of the 256 pixels with distinct amplitude pairs and reads the whole image back. This exposes a swapped row/column address or a wrong mean, since the wrong pixel or value would show up. It drives hits to one pixel at the fastest window rate until the word saturates. A pipeline without forwarding would drop increments there, and a non-saturating adder would wrap to a small value. Other runs place the row and column events in different cycles of one window, send lone events and doubled candidates, and inject events and a second clear command into a running clear. These would reveal a window cut short, a pair accepted in an ambiguous window, or a clear that is restarted or lets hits through.

// File: rtl/rcpa_pkg.sv
package rcpa_pkg;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_HIT,
        WIN_ORPHAN,
        WIN_AMBIG
    } win_outcome_e;

    // per-side candidate count, saturating at two (two means "too many")
    function automatic logic [1:0] bump2(input logic [1:0] n, input logic inc);
        if (inc && n != 2'd2) return n + 2'd1;
        return n;
    endfunction

    function automatic win_outcome_e classify(input logic [1:0] nr, input logic [1:0] nc);
        if (nr == 2'd0 && nc == 2'd0) return WIN_NONE;
        if (nr == 2'd2 || nc == 2'd2) return WIN_AMBIG;
        if (nr == 2'd1 && nc == 2'd1) return WIN_HIT;
        return WIN_ORPHAN;
    endfunction

endpackage

// File: rtl/rcpa_pair.sv
module rcpa_pair
    import rcpa_pkg::*;
#(
    parameter int GRID  = 16,
    parameter int AMP_W = 12,
    parameter int WIN   = 4,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(GRID)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             block,
    input  logic             row_valid,
    input  logic [IDX_W-1:0] row_idx,
    input  logic [AMP_W-1:0] row_amp,
    input  logic             col_valid,
    input  logic [IDX_W-1:0] col_idx,
    input  logic [AMP_W-1:0] col_amp,
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_row,
    output logic [IDX_W-1:0] evt_col,
    output logic [AMP_W-1:0] evt_row_amp,
    output logic [AMP_W-1:0] evt_col_amp,
    output logic [CNT_W-1:0] orphan_cnt,
    output logic [CNT_W-1:0] ambig_cnt
);

    localparam int AGE_W = $clog2(WIN) + 1;

    logic             open_q;
    logic [AGE_W-1:0] age_q;
    logic [1:0]       nr_q, nc_q;
    logic [IDX_W-1:0] r_idx_q, c_idx_q;
    logic [AMP_W-1:0] r_amp_q, c_amp_q;

    logic             rin, cin, closing;
    logic [1:0]       nr_base, nc_base, nr_d, nc_d;
    logic [IDX_W-1:0] r_idx_d, c_idx_d;
    logic [AMP_W-1:0] r_amp_d, c_amp_d;
    win_outcome_e     outcome;

    always_comb begin
        rin     = row_valid && !block;
        cin     = col_valid && !block;
        nr_base = open_q ? nr_q : 2'd0;
        nc_base = open_q ? nc_q : 2'd0;
        nr_d    = bump2(nr_base, rin);
        nc_d    = bump2(nc_base, cin);
        // keep the first candidate of each side
        r_idx_d = (rin && nr_base == 2'd0) ? row_idx : r_idx_q;
        r_amp_d = (rin && nr_base == 2'd0) ? row_amp : r_amp_q;
        c_idx_d = (cin && nc_base == 2'd0) ? col_idx : c_idx_q;
        c_amp_d = (cin && nc_base == 2'd0) ? col_amp : c_amp_q;
        closing = open_q && !block && (age_q == AGE_W'(WIN - 1));
        outcome = classify(nr_d, nc_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q      <= 1'b0;
            age_q       <= '0;
            nr_q        <= '0;
            nc_q        <= '0;
            r_idx_q     <= '0;
            c_idx_q     <= '0;
            r_amp_q     <= '0;
            c_amp_q     <= '0;
            evt_valid   <= 1'b0;
            evt_row     <= '0;
            evt_col     <= '0;
            evt_row_amp <= '0;
            evt_col_amp <= '0;
            orphan_cnt  <= '0;
            ambig_cnt   <= '0;
        end else begin
            evt_valid <= 1'b0;
            r_idx_q   <= r_idx_d;
            c_idx_q   <= c_idx_d;
            r_amp_q   <= r_amp_d;
            c_amp_q   <= c_amp_d;
            nr_q      <= nr_d;
            nc_q      <= nc_d;
            if (block) begin
                open_q <= 1'b0;
                nr_q   <= '0;
                nc_q   <= '0;
            end else if (closing) begin
                open_q <= 1'b0;
                nr_q   <= '0;
                nc_q   <= '0;
                case (outcome)
                    WIN_HIT: begin
                        evt_valid   <= 1'b1;
                        evt_row     <= r_idx_d;
                        evt_col     <= c_idx_d;
                        evt_row_amp <= r_amp_d;
                        evt_col_amp <= c_amp_d;
                    end
                    WIN_ORPHAN: if (orphan_cnt != '1) orphan_cnt <= orphan_cnt + 1'b1;
                    WIN_AMBIG:  if (ambig_cnt  != '1) ambig_cnt  <= ambig_cnt  + 1'b1;
                    default: ;
                endcase
            end else if (open_q) begin
                age_q <= age_q + 1'b1;
            end else if (rin || cin) begin
                open_q <= 1'b1;
                age_q  <= AGE_W'(1);
            end
        end
    end

endmodule

// File: rtl/rcpa_accum.sv
module rcpa_accum #(
    parameter int GRID  = 16,
    parameter int AMP_W = 12,
    parameter int ACC_W = 32,
    localparam int IDX_W  = $clog2(GRID),
    localparam int NPIX   = GRID * GRID,
    localparam int ADDR_W = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_valid,
    input  logic [IDX_W-1:0]  hit_row,
    input  logic [IDX_W-1:0]  hit_col,
    input  logic [AMP_W-1:0]  hit_row_amp,
    input  logic [AMP_W-1:0]  hit_col_amp,
    input  logic              clr_start,
    output logic              clr_busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [ACC_W-1:0]  rd_data
);

    localparam int SUM_W = AMP_W + 1;

    logic [ACC_W-1:0] mem [NPIX];

    function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] base,
                                                 input logic [AMP_W-1:0] inc);
        logic [ACC_W:0] s;
        s = {1'b0, base} + (ACC_W + 1)'(inc);
        return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
    endfunction

    // stage A (combinational from the reported pair)
    logic [ADDR_W-1:0] a_addr;
    logic [AMP_W-1:0]  a_amp;
    logic [SUM_W-1:0]  a_sum;
    logic [ACC_W-1:0]  a_old;
    // stage B: old value held, stage C: new value to write
    logic              b_v, c_v;
    logic [ADDR_W-1:0] b_addr, c_addr;
    logic [AMP_W-1:0]  b_amp;
    logic [ACC_W-1:0]  b_old, b_next, c_sum;
    logic [ADDR_W-1:0] clr_ptr;
    logic              flush, start;

    always_comb begin
        a_addr = ADDR_W'(hit_row) * ADDR_W'(GRID) + ADDR_W'(hit_col);
        a_sum  = SUM_W'(hit_row_amp) + SUM_W'(hit_col_amp);
        a_amp  = a_sum[SUM_W-1:1];
        b_next = sat_add(b_old, b_amp);
        a_old  = mem[a_addr];
        // forward the values still in flight; the younger one wins
        if (c_v && c_addr == a_addr) a_old = c_sum;
        if (b_v && b_addr == a_addr) a_old = b_next;
        flush  = clr_start || clr_busy;
        start  = clr_start && !clr_busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_v      <= 1'b0;
            c_v      <= 1'b0;
            b_addr   <= '0;
            c_addr   <= '0;
            b_amp    <= '0;
            b_old    <= '0;
            c_sum    <= '0;
            clr_busy <= 1'b0;
            clr_ptr  <= '0;
            rd_valid <= 1'b0;
        end else begin
            b_v      <= hit_valid && !flush;
            b_addr   <= a_addr;
            b_amp    <= a_amp;
            b_old    <= a_old;
            c_v      <= b_v && !flush;
            c_addr   <= b_addr;
            c_sum    <= b_next;
            rd_valid <= rd_en;
            if (start) begin
                clr_busy <= 1'b1;
                clr_ptr  <= '0;
            end else if (clr_busy) begin
                clr_ptr <= clr_ptr + 1'b1;
                if (clr_ptr == ADDR_W'(NPIX - 1)) clr_busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr_busy)  mem[clr_ptr] <= '0;
        else if (c_v)  mem[c_addr]  <= c_sum;
        if (rd_en)     rd_data      <= mem[rd_addr];
    end

endmodule

// File: rtl/rc_pixel_accum.sv
module rc_pixel_accum #(
    parameter int GRID  = 16,
    parameter int AMP_W = 12,
    parameter int ACC_W = 32,
    parameter int WIN   = 4,
    parameter int CNT_W = 16,
    localparam int IDX_W  = $clog2(GRID),
    localparam int ADDR_W = $clog2(GRID * GRID)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_valid,
    input  logic [IDX_W-1:0]  row_idx,
    input  logic [AMP_W-1:0]  row_amp,
    input  logic              col_valid,
    input  logic [IDX_W-1:0]  col_idx,
    input  logic [AMP_W-1:0]  col_amp,
    input  logic              clr_start,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [ACC_W-1:0]  rd_data,
    output logic              clr_busy,
    output logic              evt_valid,
    output logic [IDX_W-1:0]  evt_row,
    output logic [IDX_W-1:0]  evt_col,
    output logic [AMP_W-1:0]  evt_row_amp,
    output logic [AMP_W-1:0]  evt_col_amp,
    output logic [CNT_W-1:0]  orphan_cnt,
    output logic [CNT_W-1:0]  ambig_cnt
);

    logic block;
    assign block = clr_start || clr_busy;

    rcpa_pair #(.GRID(GRID), .AMP_W(AMP_W), .WIN(WIN), .CNT_W(CNT_W)) u_pair (
        .clk         (clk),
        .rst         (rst),
        .block       (block),
        .row_valid   (row_valid),
        .row_idx     (row_idx),
        .row_amp     (row_amp),
        .col_valid   (col_valid),
        .col_idx     (col_idx),
        .col_amp     (col_amp),
        .evt_valid   (evt_valid),
        .evt_row     (evt_row),
        .evt_col     (evt_col),
        .evt_row_amp (evt_row_amp),
        .evt_col_amp (evt_col_amp),
        .orphan_cnt  (orphan_cnt),
        .ambig_cnt   (ambig_cnt)
    );

    rcpa_accum #(.GRID(GRID), .AMP_W(AMP_W), .ACC_W(ACC_W)) u_accum (
        .clk         (clk),
        .rst         (rst),
        .hit_valid   (evt_valid),
        .hit_row     (evt_row),
        .hit_col     (evt_col),
        .hit_row_amp (evt_row_amp),
        .hit_col_amp (evt_col_amp),
        .clr_start   (clr_start),
        .clr_busy    (clr_busy),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/rc_pixel_accum_chk.sv
module rc_pixel_accum_chk #(
    parameter int GRID  = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_valid,
    input logic             clr_busy,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [CNT_W-1:0] orphan_cnt,
    input logic [CNT_W-1:0] ambig_cnt
);

    localparam int NPIX = GRID * GRID;

    logic        past_ok;
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok  <= 1'b0;
            busy_len <= '0;
        end else begin
            past_ok  <= 1'b1;
            busy_len <= clr_busy ? busy_len + 1 : '0;
        end
    end

    // R8: no pair is reported while the image is being wiped
    a_r8_quiet_in_clear: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> !clr_busy);

    // R8: the sweep never exceeds one pass and ends after exactly one pass
    a_r8_clear_bound: assert property (@(posedge clk) disable iff (rst)
        clr_busy |-> busy_len < NPIX);
    a_r8_clear_len: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(clr_busy)) |-> busy_len == NPIX);

    // R9: read data qualifies exactly one cycle after each request
    a_r9_rd_follow: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r9_rd_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R2: a report is a single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !evt_valid);

    // R5 / R6: counters only ever step up by one
    a_r5_orphan_step: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (CNT_W'(orphan_cnt - $past(orphan_cnt)) <= CNT_W'(1)));
    a_r6_ambig_step: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (CNT_W'(ambig_cnt - $past(ambig_cnt)) <= CNT_W'(1)));

endmodule

bind rc_pixel_accum rc_pixel_accum_chk #(.GRID(GRID), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_valid  (evt_valid),
    .clr_busy   (clr_busy),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .orphan_cnt (orphan_cnt),
    .ambig_cnt  (ambig_cnt)
);

// File: tb/rc_pixel_accum_bench.sv
`timescale 1ns/1ps
module rc_pixel_accum_bench;

    localparam int GRID  = 16;
    localparam int AMP_W = 10;
    localparam int ACC_W = 14;
    localparam int WIN   = 2;
    localparam int CNT_W = 16;
    localparam int NPIX  = GRID * GRID;
    localparam int MAXV  = (1 << ACC_W) - 1;

    logic             clk = 0;
    logic             rst = 1;
    logic             row_valid = 0, col_valid = 0;
    logic [3:0]       row_idx = 0, col_idx = 0;
    logic [AMP_W-1:0] row_amp = 0, col_amp = 0;
    logic             clr_start = 0, rd_en = 0;
    logic [7:0]       rd_addr = 0;
    logic             rd_valid, clr_busy, evt_valid;
    logic [ACC_W-1:0] rd_data;
    logic [3:0]       evt_row, evt_col;
    logic [AMP_W-1:0] evt_row_amp, evt_col_amp;
    logic [CNT_W-1:0] orphan_cnt, ambig_cnt;

    rc_pixel_accum #(.GRID(GRID), .AMP_W(AMP_W), .ACC_W(ACC_W), .WIN(WIN), .CNT_W(CNT_W))
    u_rc_pixel_accum (
        .clk(clk), .rst(rst),
        .row_valid(row_valid), .row_idx(row_idx), .row_amp(row_amp),
        .col_valid(col_valid), .col_idx(col_idx), .col_amp(col_amp),
        .clr_start(clr_start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .clr_busy(clr_busy),
        .evt_valid(evt_valid), .evt_row(evt_row), .evt_col(evt_col),
        .evt_row_amp(evt_row_amp), .evt_col_amp(evt_col_amp),
        .orphan_cnt(orphan_cnt), .ambig_cnt(ambig_cnt)
    );

    always #2 clk = ~clk;   // 250 MHz

    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;
    int  model [NPIX];
    int  exp_orph = 0, exp_amb = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        row_valid = 0; col_valid = 0; clr_start = 0; rd_en = 0;
    endtask

    // row and column in the same cycle; window closes one edge later
    task automatic do_hit(input int r, input int c, input int ra, input int ca, input bit check_evt);
        row_valid = 1; row_idx = 4'(r); row_amp = AMP_W'(ra);
        col_valid = 1; col_idx = 4'(c); col_amp = AMP_W'(ca);
        @(negedge clk);
        row_valid = 0; col_valid = 0;
        @(negedge clk);
        if (check_evt) begin
            chk(evt_valid === 1'b1, "R2 evt_valid", evt_valid, 1);
            chk(evt_row == 4'(r) && evt_col == 4'(c), "R2 evt indices",
                {evt_row, evt_col}, {4'(r), 4'(c)});
            chk(evt_row_amp == AMP_W'(ra) && evt_col_amp == AMP_W'(ca), "R2 evt amplitudes",
                {evt_row_amp, evt_col_amp}, {AMP_W'(ra), AMP_W'(ca)});
        end
        model[r*GRID + c] = model[r*GRID + c] + (ra + ca) / 2;
        if (model[r*GRID + c] > MAXV) model[r*GRID + c] = MAXV;
    endtask

    task automatic read_pix(input int a, output int v);
        rd_en = 1; rd_addr = 8'(a);
        @(negedge clk);
        rd_en = 0;
        chk(rd_valid === 1'b1, "R9 rd_valid", rd_valid, 1);
        v = int'(rd_data);
    endtask

    task automatic check_pix(input int a, input string req);
        int v;
        read_pix(a, v);
        chk(v == model[a], req, v, model[a]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear(input bit inject, output int len, output bit saw_evt);
        clr_start = 1;
        @(negedge clk);
        clr_start = 0;
        len = 0; saw_evt = 0;
        while (clr_busy === 1'b1 && len < 1000) begin
            len++;
            if (inject && (len == 50 || len == 51)) begin
                row_valid = 1; row_idx = 4'd3; row_amp = 10'd100;
                col_valid = (len == 50); col_idx = 4'd4; col_amp = 10'd200;
            end else begin
                row_valid = 0; col_valid = 0;
            end
            clr_start = inject && (len == 100);
            if (evt_valid) saw_evt = 1;
            @(negedge clk);
        end
        idle_inputs();
        for (int i = 0; i < NPIX; i++) model[i] = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int len, v;
        bit saw;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(evt_valid === 0 && clr_busy === 0 && rd_valid === 0, "R10 reset flags",
            {evt_valid, clr_busy, rd_valid}, 0);
        chk(orphan_cnt == 0 && ambig_cnt == 0, "R10 reset counters",
            {orphan_cnt, ambig_cnt}, 0);

        // R8 first clear
        do_clear(0, len, saw);
        chk(len == NPIX, "R8 clear length", len, NPIX);
        check_pix(0, "R8 cleared pixel 0");
        check_pix(255, "R8 cleared pixel 255");

        // R1 R2 R3 sweep over every pixel
        for (int p = 0; p < NPIX; p++)
            do_hit(p / GRID, p % GRID, (p * 37) % 1024, (p * 91 + 5) % 1024, 1);
        settle();
        for (int p = 0; p < NPIX; p++) check_pix(p, "R1 R3 pixel value");
        // R9 reading is non-destructive
        check_pix(77, "R9 reread unchanged");

        // R2 row and column in different cycles of one window
        row_valid = 1; row_idx = 4'd2; row_amp = 10'd301;
        @(negedge clk);
        row_valid = 0; col_valid = 1; col_idx = 4'd9; col_amp = 10'd100;
        @(negedge clk);
        col_valid = 0;
        chk(evt_valid === 1'b1 && evt_row == 4'd2 && evt_col == 4'd9, "R2 split window",
            {evt_valid, evt_row, evt_col}, {1'b1, 4'd2, 4'd9});
        model[2*GRID + 9] += (301 + 100) / 2;
        settle();
        check_pix(2*GRID + 9, "R2 R3 split window pixel");

        // R5 orphans: lone row, then lone column
        row_valid = 1; row_idx = 4'd5; row_amp = 10'd500;
        @(negedge clk);
        row_valid = 0;
        @(negedge clk);
        exp_orph++;
        chk(evt_valid === 1'b0, "R5 no event for lone row", evt_valid, 0);
        chk(orphan_cnt == CNT_W'(exp_orph), "R5 orphan count row", orphan_cnt, exp_orph);
        col_valid = 1; col_idx = 4'd6; col_amp = 10'd500;
        @(negedge clk);
        col_valid = 0;
        @(negedge clk);
        exp_orph++;
        chk(orphan_cnt == CNT_W'(exp_orph), "R5 orphan count col", orphan_cnt, exp_orph);
        settle();
        check_pix(5*GRID + 6, "R5 pixel unchanged");

        // R6 ambiguous: two rows with one column
        row_valid = 1; row_idx = 4'd7; row_amp = 10'd400;
        col_valid = 1; col_idx = 4'd8; col_amp = 10'd400;
        @(negedge clk);
        col_valid = 0; row_idx = 4'd10;
        @(negedge clk);
        row_valid = 0;
        exp_amb++;
        chk(evt_valid === 1'b0, "R6 no event when ambiguous", evt_valid, 0);
        chk(ambig_cnt == CNT_W'(exp_amb), "R6 ambiguous count", ambig_cnt, exp_amb);
        chk(orphan_cnt == CNT_W'(exp_orph), "R6 orphan count untouched", orphan_cnt, exp_orph);
        settle();
        check_pix(7*GRID + 8, "R6 pixel 7,8 unchanged");
        check_pix(10*GRID + 8, "R6 pixel 10,8 unchanged");

        // R8 clear with injected events and a second start pulse
        do_clear(1, len, saw);
        chk(len == NPIX, "R8 clear length with restart pulse", len, NPIX);
        chk(saw == 0, "R8 no event during clear", saw, 0);
        chk(orphan_cnt == CNT_W'(exp_orph) && ambig_cnt == CNT_W'(exp_amb),
            "R8 counters untouched by clear", {orphan_cnt, ambig_cnt}, {16'(exp_orph), 16'(exp_amb)});
        settle();
        check_pix(3*GRID + 4, "R8 injected hit ignored");
        for (int p = 0; p < NPIX; p += 17) check_pix(p, "R8 image zero");

        // R7 R4 back-to-back hits to one pixel until saturation
        for (int k = 0; k < 20; k++) begin
            do_hit(12, 3, 1000, 1001, 0);
            if (k == 9) begin
                settle();
                check_pix(12*GRID + 3, "R7 ten back-to-back hits");
            end
        end
        settle();
        check_pix(12*GRID + 3, "R4 saturated pixel");
        // R7 interleaved neighbours at full rate
        for (int k = 0; k < 8; k++) do_hit(1, k % 2, 11 * k, 3, 0);
        settle();
        check_pix(1*GRID + 0, "R7 interleave pixel 1,0");
        check_pix(1*GRID + 1, "R7 interleave pixel 1,1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule